// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block decides, one cycle at a time, whether the processor core enters a trap, returns from one, or carries on. It takes a synchronous exception reported by the pipeline with its 5-bit cause code, an exception-return request, the vector of pending interrupt lines, the current PC and the exception vector address. It owns the three control registers that a trap changes: the status word, the saved exception PC and the cause. When a trap or return is taken, it drives a PC redirect in the same cycle. The register updates take effect on the next clock edge.

Interrupts are arbitrated inside the block. A line competes only when its mask bit in the status word is set, and only while traps are enabled. The lowest-numbered competing line wins. An interrupt cause is the line index with the top bit of the cause word set. A synchronous exception always beats a return request, and a return request beats an interrupt. A return that is not allowed becomes a trap with the matching cause code. The control-register path can load the status word through a plain write strobe. Bits for features that are not built in, and bits that are not defined, are dropped on the write.

All pins are plain control and status signals sampled every cycle. There is no valid/ready stream and so no back-pressure: each request is resolved in the cycle it is presented.

Top module: `trap_sequencer`

## Requirements
- R1: When a trap is taken, `redirect_valid` and `trap_taken` are 1 in that cycle and `redirect_pc` equals `evec_in`. After the next edge the status has bit 0 (trap enable) at 0, bit 5 (supervisor) at 1, and bit 4 (previous supervisor) equal to the old bit 5. `epc_q` then equals the `pc_in` of the trap cycle.
- R2: An interrupt is taken only when status bit 0 is 1 and `irq_pending[i]` is 1 for some line i whose mask bit, status bit 16+i, is also 1.
- R3: Among competing interrupt lines the lowest index wins. The cause written is the index with bit XLEN-1 set.
- R4: A synchronous exception (`exc_valid`) is taken whatever the status, the return request or the pending interrupts. Its cause is `exc_code` zero-extended.
- R5: A return request is accepted when status bit 5 is 1 and bit 0 is 0. It then redirects to `epc_q` with `trap_taken` at 0 and sets bit 0. It keeps bit 5 if bit 4 was 1 and clears it otherwise. `epc_q` and `cause_q` are left unchanged.
- R6: A return request with bit 5 at 0 becomes a trap with cause 3. One with bit 5 at 1 and bit 0 at 1 becomes a trap with cause 2.
- R7: After reset the status holds bits 0 and 5 and all mask bits (plus bit 7 when the wide-mode feature is built). `epc_q` and `cause_q` are 0, and no redirect is driven.
- R8: A status write keeps only the implemented bits: 0, 4, 5, 8, 16..16+NIRQ-1, and the feature bits that are built (1 float, 2 vector, 3 compressed, 6 and 7 wide mode). A write in a cycle that takes a trap or a return is ignored.
- R9: In a cycle with no trap, no return and no write, the status, `epc_q` and `cause_q` hold their values and `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Synchronous exception this cycle |
| exc_code | input | 5 | Cause code of the exception |
| ret_req | input | 1 | Exception-return instruction this cycle |
| irq_pending | input | NIRQ | Pending interrupt lines |
| sts_wr_en | input | 1 | Status write strobe from the control-register path |
| sts_wr_data | input | 32 | Status write value |
| pc_in | input | XLEN | PC of the current instruction |
| evec_in | input | XLEN | Exception vector address |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| trap_taken | output | 1 | Redirect is a trap entry |
| status_q | output | 32 | Status word |
| epc_q | output | XLEN | Saved exception PC |
| cause_q | output | XLEN | Trap cause |

## Verification
The bench builds the block with XLEN 32, eight interrupt lines and only the float feature enabled. This gives a legal-bit mask of 0x00FF0133 and a reset status of 0x00FF0021. With eight lines, every one of the 256 pending patterns can be swept under several mask patterns and with traps disabled, and each winner is checked against a lowest-set-bit search. All 32 exception codes and all eight combinations of trap-enable, supervisor and previous-supervisor bits on a return are covered. A walking-one write over all 32 status bits exercises the write filter.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int ST_W        = 32;
  localparam int ST_TEN      = 0;   // traps enabled
  localparam int ST_FPEN     = 1;
  localparam int ST_VECEN    = 2;
  localparam int ST_CMPEN    = 3;
  localparam int ST_PSUP     = 4;   // supervisor before the last trap
  localparam int ST_SUP      = 5;   // supervisor now
  localparam int ST_UWIDE    = 6;
  localparam int ST_SWIDE    = 7;
  localparam int ST_VMEN     = 8;
  localparam int ST_MASK_LSB = 16;  // interrupt mask field base

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 5'd2;
  localparam logic [CODE_W-1:0] CODE_PRIV    = 5'd3;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_TRAP   = 2'd1,
    EV_RETURN = 2'd2
  } ev_kind_e;

  function automatic logic [ST_W-1:0] legal_mask(input int nirq, input bit fp,
                                                 input bit vec, input bit cmp,
                                                 input bit wide);
    logic [ST_W-1:0] m;
    m           = '0;
    m[ST_TEN]   = 1'b1;
    m[ST_PSUP]  = 1'b1;
    m[ST_SUP]   = 1'b1;
    m[ST_VMEN]  = 1'b1;
    m[ST_FPEN]  = fp;
    m[ST_VECEN] = vec;
    m[ST_CMPEN] = cmp;
    m[ST_UWIDE] = wide;
    m[ST_SWIDE] = wide;
    for (int i = 0; i < nirq; i++) m[ST_MASK_LSB+i] = 1'b1;
    return m;
  endfunction

  function automatic logic [ST_W-1:0] reset_raw(input int nirq);
    logic [ST_W-1:0] r;
    r           = '0;
    r[ST_TEN]   = 1'b1;
    r[ST_SUP]   = 1'b1;
    r[ST_SWIDE] = 1'b1;
    for (int i = 0; i < nirq; i++) r[ST_MASK_LSB+i] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int NIRQ  = 8,
  parameter int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NIRQ-1:0]  pending,
  input  logic [NIRQ-1:0]  mask,
  output logic             req,
  output logic [IDX_W-1:0] idx
);
  logic [NIRQ-1:0] active;
  logic [NIRQ:0]   below;
  logic [NIRQ-1:0] grant;

  assign active   = pending & mask & {NIRQ{enable}};
  assign below[0] = 1'b0;

  for (genvar g = 0; g < NIRQ; g++) begin : g_chain
    assign grant[g]   = active[g] & ~below[g];
    assign below[g+1] = below[g] | active[g];
  end

  assign req = below[NIRQ];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++)
      if (grant[i]) idx = idx | IDX_W'(i);
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_WINNER_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((active & ((NIRQ'(1) << idx) - NIRQ'(1))) == '0)); // R3
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 3
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              ret_req,
  input  logic              sup,
  input  logic              ten,
  input  logic              irq_req,
  input  logic [IDX_W-1:0]  irq_idx,
  output ev_kind_e          kind,
  output logic [XLEN-1:0]   cause_nxt
);
  always_comb begin
    kind      = EV_NONE;
    cause_nxt = '0;
    if (exc_valid) begin
      kind      = EV_TRAP;
      cause_nxt = XLEN'(exc_code);
    end else if (ret_req) begin
      if (!sup) begin
        kind      = EV_TRAP;
        cause_nxt = XLEN'(CODE_PRIV);
      end else if (ten) begin
        kind      = EV_TRAP;
        cause_nxt = XLEN'(CODE_ILLEGAL);
      end else begin
        kind      = EV_RETURN;
      end
    end else if (irq_req) begin
      kind                   = EV_TRAP;
      cause_nxt[XLEN-1]      = 1'b1;
      cause_nxt[IDX_W-1:0]   = irq_idx;
    end
  end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_seq_pkg::*;
#(
  parameter int NIRQ     = 8,
  parameter bit HAS_FP   = 1'b0,
  parameter bit HAS_VEC  = 1'b0,
  parameter bit HAS_CMP  = 1'b0,
  parameter bit HAS_WIDE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ev_kind_e        kind,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_data,
  output logic [ST_W-1:0] status
);
  localparam logic [ST_W-1:0] LEGAL = legal_mask(NIRQ, HAS_FP, HAS_VEC, HAS_CMP, HAS_WIDE);
  localparam logic [ST_W-1:0] RST   = reset_raw(NIRQ) & LEGAL;

  logic [ST_W-1:0] nxt;

  always_comb begin
    nxt = status;
    unique case (kind)
      EV_TRAP: begin
        nxt[ST_TEN]  = 1'b0;
        nxt[ST_PSUP] = status[ST_SUP];
        nxt[ST_SUP]  = 1'b1;
      end
      EV_RETURN: begin
        nxt[ST_TEN] = 1'b1;
        if (!status[ST_PSUP]) nxt[ST_SUP] = 1'b0;
      end
      default: if (wr_en) nxt = wr_data & LEGAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status <= RST;
    else        status <= nxt;

  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    kind == EV_TRAP |=> !status[ST_TEN] && status[ST_SUP]
                        && (status[ST_PSUP] == $past(status[ST_SUP]))); // R1
  AST_RETURN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    kind == EV_RETURN |=> status[ST_TEN]
                          && (status[ST_SUP] == $past(status[ST_PSUP]))); // R5
  AST_WRITE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == EV_NONE) |=> status == ($past(wr_data) & LEGAL)); // R8
  AST_NO_ILLEGAL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~LEGAL) == '0); // R8
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NIRQ     = 8,
  parameter bit HAS_FP   = 1'b1,
  parameter bit HAS_VEC  = 1'b0,
  parameter bit HAS_CMP  = 1'b0,
  parameter bit HAS_WIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [4:0]        exc_code,
  input  logic              ret_req,
  input  logic [NIRQ-1:0]   irq_pending,
  input  logic              sts_wr_en,
  input  logic [31:0]       sts_wr_data,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   evec_in,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              trap_taken,
  output logic [31:0]       status_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q
);
  localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic             irq_req;
  logic [IDX_W-1:0] irq_idx;
  ev_kind_e         kind;
  logic [XLEN-1:0]  cause_nxt;

  trap_irq_pick #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (status_q[ST_TEN]),
    .pending (irq_pending),
    .mask    (status_q[ST_MASK_LSB +: NIRQ]),
    .req     (irq_req),
    .idx     (irq_idx)
  );

  trap_decide #(.XLEN(XLEN), .IDX_W(IDX_W)) u_decide (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .ret_req   (ret_req),
    .sup       (status_q[ST_SUP]),
    .ten       (status_q[ST_TEN]),
    .irq_req   (irq_req),
    .irq_idx   (irq_idx),
    .kind      (kind),
    .cause_nxt (cause_nxt)
  );

  trap_status_reg #(
    .NIRQ(NIRQ), .HAS_FP(HAS_FP), .HAS_VEC(HAS_VEC),
    .HAS_CMP(HAS_CMP), .HAS_WIDE(HAS_WIDE)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .wr_en   (sts_wr_en),
    .wr_data (sts_wr_data),
    .status  (status_q)
  );

  assign trap_taken     = (kind == EV_TRAP);
  assign redirect_valid = (kind != EV_NONE);
  assign redirect_pc    = trap_taken ? evec_in : epc_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (trap_taken) begin
      epc_q   <= pc_in;
      cause_q <= cause_nxt;
    end

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> epc_q == $past(pc_in)); // R1
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[ST_TEN] && !exc_valid && !ret_req) |-> !redirect_valid); // R2
  AST_IRQ_CAUSE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && !exc_valid && !ret_req) |=> cause_q[XLEN-1]); // R3
  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> trap_taken && (redirect_pc == evec_in)); // R4
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !trap_taken) |=> $stable(epc_q) && $stable(cause_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_valid && !sts_wr_en) |=>
      $stable(status_q) && $stable(epc_q) && $stable(cause_q)); // R9
endmodule

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;
  localparam logic [31:0] LEGAL = 32'h00FF0133;
  localparam logic [31:0] EVEC  = 32'h0000_2000;
  localparam logic [31:0] B_TEN = 32'h1, B_PSUP = 32'h10, B_SUP = 32'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 1'b0;
  logic [4:0] exc_code = '0;
  logic ret_req = 1'b0;
  logic [7:0] irq_pending = '0;
  logic sts_wr_en = 1'b0;
  logic [31:0] sts_wr_data = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] evec_in = EVEC;
  logic redirect_valid, trap_taken;
  logic [31:0] redirect_pc, status_q, epc_q, cause_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_sequencer uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .ret_req(ret_req), .irq_pending(irq_pending), .sts_wr_en(sts_wr_en),
    .sts_wr_data(sts_wr_data), .pc_in(pc_in), .evec_in(evec_in),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .trap_taken(trap_taken), .status_q(status_q), .epc_q(epc_q), .cause_q(cause_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_of(input logic [31:0] s);
    logic [31:0] r;
    r = (s & ~(B_TEN | B_PSUP)) | B_SUP;
    if ((s & B_SUP) != 0) r = r | B_PSUP;
    return r;
  endfunction

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic wr_status(input logic [31:0] v);
    sts_wr_en = 1'b1; sts_wr_data = v;
    @(posedge clk); #1;
    sts_wr_en = 1'b0;
  endtask

  task automatic clear_in();
    exc_valid = 1'b0; ret_req = 1'b0; irq_pending = '0; sts_wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, old_cause, old_epc;
    logic [7:0]  masks [5];
    masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'hA5; masks[3] = 8'h5A; masks[4] = 8'h81;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset status", status_q, 32'h00FF0021);
    chk("R7 reset epc", epc_q, 32'h0);
    chk("R7 reset cause", cause_q, 32'h0);
    chk("R7 no redirect", {31'b0, redirect_valid}, 32'h0);
    @(posedge clk); #1;

    // R8 walking one through the write filter
    for (int b = 0; b < 32; b++) begin
      wr_status(32'h1 << b);
      chk("R8 write filter", status_q, (32'h1 << b) & LEGAL);
    end
    wr_status(32'hFFFF_FFFF);
    chk("R8 write all ones", status_q, LEGAL);

    // R8 write ignored when a trap is taken
    wr_status(32'h00FF0021);
    pc_in = 32'h0000_0400; exc_valid = 1'b1; exc_code = 5'd9;
    sts_wr_en = 1'b1; sts_wr_data = 32'h0000_0000;
    @(posedge clk); #1; clear_in();
    chk("R8 write lost to trap", status_q, entry_of(32'h00FF0021));

    // R2 R3 sweep of pending patterns under masks, plus traps disabled
    for (int c = 0; c < 6; c++) begin
      for (int p = 0; p < 256; p++) begin
        logic [7:0] m, act;
        m = (c < 5) ? masks[c] : 8'hFF;
        s = {8'h00, m, 16'h0000} | B_SUP | ((c < 5) ? B_TEN : 32'h0);
        wr_status(s);
        old_cause = cause_q; old_epc = epc_q;
        irq_pending = p[7:0]; pc_in = 32'h100 + 32'(p) * 4;
        act = (c < 5) ? (p[7:0] & m) : 8'h00;
        @(negedge clk);
        chk("R2 irq redirect", {31'b0, redirect_valid}, {31'b0, act != 0});
        if (act != 0) chk("R1 irq target", redirect_pc, EVEC);
        @(posedge clk); #1; clear_in();
        if (act != 0) begin
          chk("R3 irq cause", cause_q, 32'h8000_0000 | 32'(lowest(act)));
          chk("R1 irq epc", epc_q, 32'h100 + 32'(p) * 4);
          chk("R1 irq status", status_q, entry_of(s));
        end else begin
          chk("R9 hold status", status_q, s);
          chk("R9 hold cause", cause_q, old_cause);
          chk("R9 hold epc", epc_q, old_epc);
        end
      end
    end

    // R4 every exception code, beating return and interrupts, from both modes
    for (int u = 0; u < 2; u++) begin
      for (int k = 0; k < 32; k++) begin
        s = (u == 0) ? 32'h00FF0021 : 32'h00FF0001;
        wr_status(s);
        exc_valid = 1'b1; exc_code = 5'(k); ret_req = 1'b1; irq_pending = 8'hFF;
        pc_in = 32'h8000 + 32'(k);
        @(negedge clk);
        chk("R4 exc redirect", {30'b0, redirect_valid, trap_taken}, 32'h3);
        chk("R4 exc target", redirect_pc, EVEC);
        @(posedge clk); #1; clear_in();
        chk("R4 exc cause", cause_q, 32'(k));
        chk("R1 exc status", status_q, entry_of(s));
        chk("R1 exc epc", epc_q, 32'h8000 + 32'(k));
      end
    end

    // R5 R6 return under all TEN/SUP/PSUP combinations
    for (int t = 0; t < 8; t++) begin
      wr_status(32'h00FF0021);
      exc_valid = 1'b1; exc_code = 5'd7; pc_in = 32'h1234_5670;
      @(posedge clk); #1; clear_in();
      s = 32'h00FF0000 | (t[0] ? B_SUP : 0) | (t[1] ? B_PSUP : 0) | (t[2] ? B_TEN : 0);
      wr_status(s);
      ret_req = 1'b1; irq_pending = 8'hFF; pc_in = 32'h0000_0900;
      @(negedge clk);
      chk("R5 R6 redirect", {31'b0, redirect_valid}, 32'h1);
      if (!t[0]) begin
        chk("R6 priv trap", {31'b0, trap_taken}, 32'h1);
        @(posedge clk); #1; clear_in();
        chk("R6 priv cause", cause_q, 32'd3);
        chk("R6 priv epc", epc_q, 32'h0000_0900);
      end else if (t[2]) begin
        chk("R6 illegal trap", {31'b0, trap_taken}, 32'h1);
        @(posedge clk); #1; clear_in();
        chk("R6 illegal cause", cause_q, 32'd2);
        chk("R6 illegal status", status_q, entry_of(s));
      end else begin
        chk("R5 ret not trap", {31'b0, trap_taken}, 32'h0);
        chk("R5 ret target", redirect_pc, 32'h1234_5670);
        @(posedge clk); #1; clear_in();
        chk("R5 ret status", status_q, (t[1] ? s : (s & ~B_SUP)) | B_TEN);
        chk("R5 ret epc kept", epc_q, 32'h1234_5670);
        chk("R5 ret cause kept", cause_q, 32'd7);
      end
    end

    // R9 idle cycles
    s = status_q; old_epc = epc_q; old_cause = cause_q;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 idle status", status_q, s);
    chk("R9 idle epc", epc_q, old_epc);
    chk("R9 idle cause", cause_q, old_cause);
    chk("R9 idle redirect", {31'b0, redirect_valid}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule